// File: doc/BRIEF.md
# Bus-Master Disk DMA Register Block

This block holds the software-visible control and status state of a bus-master disk DMA engine. Software reaches it over a simple 32-bit word register port with byte enables. It programs a 32-bit descriptor-table base, picks a transfer direction and starts or stops the engine. The engine reports back through pulse inputs that set an active flag, an error flag and an interrupt flag. Software clears the error and interrupt flags by writing ones to them. Two per-drive DMA-capable bits share the status byte and behave as ordinary read/write storage.

Alongside the registers, a combinational judge reads the live status byte and produces two verdicts. The first is an end-of-transfer result: clean, or a failure code. The second is a timeout class that tells a supervisor whether to keep waiting, fail the request or reset the bus. Data movement, descriptor fetch and disk-side timing sit outside this block.

Word 0 carries the command byte in byte lane 0 and the status byte in byte lane 2; all other lanes of word 0 read zero. Word 1 is the descriptor-table base.

Top module: `bmdma_regs`

## Requirements
- R1: After reset the command byte, the status flags, the drive bits and the table base are all zero, and dma_go, dma_to_mem and irq_out are low.
- R2: A write to word 0 with reg_be[0] set loads command bit 0 (start, driven on dma_go) and command bit 3 (direction, driven on dma_to_mem, 1 = into memory); every other command bit reads zero.
- R3: Word 1 is a 32-bit table base that is written per byte lane under reg_be, is driven on table_base and reads back unchanged.
- R4: Status bits 5 and 6 are the DMA-capable flags for drive 0 and drive 1; a write to word 0 with reg_be[2] set loads them from reg_wdata[21] and reg_wdata[22].
- R5: Status bit 1 (error) is set by an eng_err pulse and status bit 2 (interrupt) by an eng_irq pulse; each is cleared only by writing a one to it in a status write; writing zero leaves it unchanged.
- R6: When an engine pulse that sets the error or interrupt flag lands in the same cycle as a software write clearing that flag, the flag ends up set.
- R7: Status bit 0 (active) is read-only. It rises on a command write that takes start from 0 to 1. It falls on eng_done or eng_err. Rewriting start while start is already 1 does not raise it.
- R8: Status bits 3 and 4 show the two eng_busy lines live; status bit 7 reads zero.
- R9: end_fail is low and end_code is 0x00 exactly when, among status bits 2:0, only the interrupt bit is set; otherwise end_fail is high and end_code is the status byte ORed with 0x10.
- R10: tmo_class is 0 (wait) if status bits 3 and 4 are both set; else 1 (fail) if error is set; else 0 if active or interrupt is set; else 2 (reset bus).
- R11: irq_out equals status bit 2.
- R12: Word addresses other than 0 and 1 read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address |
| reg_be | input | 4 | Byte-lane enables for writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed word |
| eng_done | input | 1 | Engine reached end of descriptor table |
| eng_err | input | 1 | Engine error pulse |
| eng_irq | input | 1 | Engine interrupt pulse |
| eng_busy | input | 2 | Engine busy indicators shown in status bits 3 and 4 |
| dma_go | output | 1 | Start bit to the engine |
| dma_to_mem | output | 1 | Direction: 1 moves data into memory |
| table_base | output | 32 | Descriptor-table base address |
| irq_out | output | 1 | Interrupt request |
| end_fail | output | 1 | Transfer termination judged bad |
| end_code | output | 8 | 0 on good end, else status ORed with 0x10 |
| tmo_class | output | 2 | Timeout verdict: 0 wait, 1 fail, 2 reset bus |

## Verification
The bench lands an error pulse in the same cycle as a write-one clear of that flag. A design that let software win would read zero there. It rewrites start while start is already set, where a level-sensitive arm would re-raise active. It also writes a one to the read-only active bit, which a plain read/write field would store. The judge is driven through the status patterns that separate the classifier's priority order: busy with error still waits, error alone fails, interrupt alone is a clean end, and an all-clear status asks for a bus reset. A reordered or incomplete mask gives the wrong class or code on at least one of these.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
    localparam int CMD_START_BIT = 0;
    localparam int CMD_DIR_BIT   = 3;
    localparam int ST_ACT        = 0;
    localparam int ST_ERR        = 1;
    localparam int ST_IRQ        = 2;
    localparam int ST_BUSY_LO    = 3;
    localparam int ST_DRV_LO     = 5;
    localparam logic [7:0] FAIL_MARK = 8'h10;

    typedef enum logic [1:0] {
        TMO_WAIT  = 2'd0,
        TMO_FAIL  = 2'd1,
        TMO_RESET = 2'd2
    } tmo_e;
endpackage

// File: rtl/bmdma_cmd_reg.sv
module bmdma_cmd_reg
    import bmdma_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wbyte,
    output logic [7:0] cmd_byte,
    output logic       start,
    output logic       dir,
    output logic       start_set
);
    typedef struct packed {
        logic start;
        logic dir;
    } cmd_s;

    cmd_s q, d;

    always_comb begin
        d = q;
        if (wr_en) begin
            d.start = wbyte[CMD_START_BIT];
            d.dir   = wbyte[CMD_DIR_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        cmd_byte                = '0;
        cmd_byte[CMD_START_BIT] = q.start;
        cmd_byte[CMD_DIR_BIT]   = q.dir;
    end

    assign start     = q.start;
    assign dir       = q.dir;
    assign start_set = wr_en && wbyte[CMD_START_BIT] && !q.start;

    // R2: start holds when no command write arrives
    p_start_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(start));
    // R7: an arming write leaves start set
    p_arm_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start_set |=> start);
endmodule

// File: rtl/bmdma_status_reg.sv
module bmdma_status_reg
    import bmdma_pkg::*;
#(
    parameter int DRIVES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wbyte,
    input  logic              start_set,
    input  logic              eng_done,
    input  logic              eng_err,
    input  logic              eng_irq,
    input  logic [1:0]        eng_busy,
    output logic [7:0]        stat_byte
);
    localparam int DRV_TOP = ST_DRV_LO + DRIVES - 1;

    typedef struct packed {
        logic              act;
        logic              err;
        logic              irq;
        logic [DRIVES-1:0] drv;
    } stat_s;

    stat_s q, d;

    always_comb begin
        d = q;
        if (start_set)                d.act = 1'b1;
        else if (eng_done || eng_err) d.act = 1'b0;
        d.err = eng_err || (q.err && !(wr_en && wbyte[ST_ERR]));
        d.irq = eng_irq || (q.irq && !(wr_en && wbyte[ST_IRQ]));
        if (wr_en) d.drv = wbyte[DRV_TOP:ST_DRV_LO];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        stat_byte                         = '0;
        stat_byte[ST_ACT]                 = q.act;
        stat_byte[ST_ERR]                 = q.err;
        stat_byte[ST_IRQ]                 = q.irq;
        stat_byte[ST_BUSY_LO+1:ST_BUSY_LO] = eng_busy;
        stat_byte[DRV_TOP:ST_DRV_LO]      = q.drv;
    end

    // R5: engine error pulse sets the flag
    p_err_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        eng_err |=> stat_byte[ST_ERR]);
    // R5: write-one clears error when no pulse competes
    p_err_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wbyte[ST_ERR] && !eng_err) |=> !stat_byte[ST_ERR]);
    // R6: interrupt pulse beats a simultaneous clear
    p_irq_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_irq && wr_en && wbyte[ST_IRQ]) |=> stat_byte[ST_IRQ]);
    // R7: active falls only after an engine end or error
    p_act_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_byte[ST_ACT]) |-> $past(eng_done || eng_err));
    // R7: active rises only after an arming command write
    p_act_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_byte[ST_ACT]) |-> $past(start_set));
endmodule

// File: rtl/bmdma_judge.sv
module bmdma_judge
    import bmdma_pkg::*;
(
    input  logic [7:0] stat,
    output logic       end_fail,
    output logic [7:0] end_code,
    output tmo_e       tmo_class
);
    logic [2:0] core;
    logic       busy_pat;

    assign core     = {stat[ST_IRQ], stat[ST_ERR], stat[ST_ACT]};
    assign busy_pat = stat[ST_BUSY_LO] && stat[ST_BUSY_LO+1];

    always_comb begin
        end_fail = (core != 3'b100);
        end_code = end_fail ? (stat | FAIL_MARK) : 8'h00;
    end

    always_comb begin
        if (busy_pat)              tmo_class = TMO_WAIT;
        else if (stat[ST_ERR])     tmo_class = TMO_FAIL;
        else if (stat[ST_ACT])     tmo_class = TMO_WAIT;
        else if (stat[ST_IRQ])     tmo_class = TMO_WAIT;
        else                       tmo_class = TMO_RESET;
    end
endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
    import bmdma_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter int DATA_W    = 32,
    parameter int CMD_WORD  = 0,
    parameter int BASE_WORD = 1,
    parameter int DRIVES    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W/8-1:0] reg_be,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              eng_done,
    input  logic              eng_err,
    input  logic              eng_irq,
    input  logic [1:0]        eng_busy,
    output logic              dma_go,
    output logic              dma_to_mem,
    output logic [DATA_W-1:0] table_base,
    output logic              irq_out,
    output logic              end_fail,
    output logic [7:0]        end_code,
    output logic [1:0]        tmo_class
);
    localparam int LANES    = DATA_W / 8;
    localparam int CMD_LANE = 0;
    localparam int ST_LANE  = 2;

    logic       sel_cmd_word, sel_base_word;
    logic       wr_cmd, wr_stat;
    logic [7:0] cmd_byte, stat_byte;
    logic       start_set;
    tmo_e       tmo_int;

    assign sel_cmd_word  = (reg_addr == ADDR_W'(CMD_WORD));
    assign sel_base_word = (reg_addr == ADDR_W'(BASE_WORD));
    assign wr_cmd        = reg_wr && sel_cmd_word && reg_be[CMD_LANE];
    assign wr_stat       = reg_wr && sel_cmd_word && reg_be[ST_LANE];

    bmdma_cmd_reg u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_cmd),
        .wbyte     (reg_wdata[CMD_LANE*8 +: 8]),
        .cmd_byte  (cmd_byte),
        .start     (dma_go),
        .dir       (dma_to_mem),
        .start_set (start_set)
    );

    bmdma_status_reg #(.DRIVES(DRIVES)) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_stat),
        .wbyte     (reg_wdata[ST_LANE*8 +: 8]),
        .start_set (start_set),
        .eng_done  (eng_done),
        .eng_err   (eng_err),
        .eng_irq   (eng_irq),
        .eng_busy  (eng_busy),
        .stat_byte (stat_byte)
    );

    bmdma_judge u_judge (
        .stat      (stat_byte),
        .end_fail  (end_fail),
        .end_code  (end_code),
        .tmo_class (tmo_int)
    );

    assign tmo_class = tmo_int;
    assign irq_out   = stat_byte[ST_IRQ];

    logic [DATA_W-1:0] base_d, base_q;

    for (genvar g = 0; g < LANES; g++) begin : g_base_lane
        always_comb begin
            base_d[g*8 +: 8] = base_q[g*8 +: 8];
            if (reg_wr && sel_base_word && reg_be[g])
                base_d[g*8 +: 8] = reg_wdata[g*8 +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) base_q <= '0;
        else        base_q <= base_d;
    end

    assign table_base = base_q;

    always_comb begin
        reg_rdata = '0;
        if (sel_cmd_word) begin
            reg_rdata[CMD_LANE*8 +: 8] = cmd_byte;
            reg_rdata[ST_LANE*8 +: 8]  = stat_byte;
        end else if (sel_base_word) begin
            reg_rdata = base_q;
        end
    end

    // R3: base changes only under a base-word write
    p_base_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && sel_base_word) |=> $stable(table_base));
    // R10: fail verdict needs error and no busy pattern
    p_tmo_fail_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_class == 2'd1) |-> (stat_byte[ST_ERR] && !(stat_byte[3] && stat_byte[4])));
    // R9: a clean end implies no error and no active transfer
    p_end_ok_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !end_fail |-> (irq_out && !stat_byte[ST_ERR] && !stat_byte[ST_ACT]));
    // R11: interrupt line tracks the pending-interrupt flag
    p_irq_line_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> $past(eng_irq));
endmodule

// File: tb/tb_bmdma_regs.sv
module tb_bmdma_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [3:0]  reg_be = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        eng_done = 1'b0, eng_err = 1'b0, eng_irq = 1'b0;
    logic [1:0]  eng_busy = '0;
    logic        dma_go, dma_to_mem, irq_out, end_fail;
    logic [31:0] table_base;
    logic [7:0]  end_code;
    logic [1:0]  tmo_class;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    bmdma_regs dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_done(eng_done), .eng_err(eng_err), .eng_irq(eng_irq),
        .eng_busy(eng_busy), .dma_go(dma_go), .dma_to_mem(dma_to_mem),
        .table_base(table_base), .irq_out(irq_out), .end_fail(end_fail),
        .end_code(end_code), .tmo_class(tmo_class)
    );

    typedef struct packed {
        logic        wr;
        logic [1:0]  addr;
        logic [3:0]  be;
        logic [31:0] wd;
        logic [2:0]  eng;   // {done, err, irq}
        logic [1:0]  busy;
        logic [1:0]  raddr;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'd1, 4'b1111, 32'h1234_5678, 3'b000, 2'b00, 2'd1, 32'h1234_5678}, // R3
        '{1'b1, 2'd1, 4'b0010, 32'hAAAA_BBCC, 3'b000, 2'b00, 2'd1, 32'h1234_BB78}, // R3
        '{1'b1, 2'd0, 4'b0001, 32'h0000_00FF, 3'b000, 2'b00, 2'd0, 32'h0001_0009}, // R2 R7
        '{1'b0, 2'd0, 4'b0000, 32'h0000_0000, 3'b001, 2'b00, 2'd0, 32'h0005_0009}, // R5
        '{1'b1, 2'd0, 4'b0001, 32'h0000_0008, 3'b100, 2'b00, 2'd0, 32'h0004_0008}, // R7
        '{1'b1, 2'd0, 4'b0100, 32'h0060_0000, 3'b000, 2'b00, 2'd0, 32'h0064_0008}, // R4 R5
        '{1'b1, 2'd0, 4'b0100, 32'h0024_0000, 3'b000, 2'b00, 2'd0, 32'h0020_0008}, // R4 R5
        '{1'b1, 2'd0, 4'b0100, 32'h0022_0000, 3'b010, 2'b00, 2'd0, 32'h0022_0008}, // R6
        '{1'b0, 2'd0, 4'b0000, 32'h0000_0000, 3'b000, 2'b11, 2'd0, 32'h003A_0008}, // R8
        '{1'b1, 2'd2, 4'b1111, 32'hFFFF_FFFF, 3'b000, 2'b00, 2'd2, 32'h0000_0000}, // R12
        '{1'b1, 2'd3, 4'b1111, 32'hFFFF_FFFF, 3'b000, 2'b00, 2'd1, 32'h1234_BB78}  // R12
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic wr, input logic [1:0] addr, input logic [3:0] be,
                        input logic [31:0] wd, input logic [2:0] eng, input logic [1:0] busy,
                        input logic [1:0] raddr);
        reg_wr = wr; reg_addr = addr; reg_be = be; reg_wdata = wd;
        {eng_done, eng_err, eng_irq} = eng;
        eng_busy = busy;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = raddr; reg_be = '0; reg_wdata = '0;
        {eng_done, eng_err, eng_irq} = 3'b000;
        #1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        reg_addr = 2'd0; #1;
        check("R1 word0", reg_rdata, 32'h0);
        reg_addr = 2'd1; #1;
        check("R1 base", reg_rdata, 32'h0);
        check("R1 outputs", {29'h0, dma_go, dma_to_mem, irq_out}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            step(VECS[i].wr, VECS[i].addr, VECS[i].be, VECS[i].wd,
                 VECS[i].eng, VECS[i].busy, VECS[i].raddr);
            check($sformatf("vector %0d", i), reg_rdata, VECS[i].exp);
        end
        check("R3 table_base port", table_base, 32'h1234_BB78);

        // status now 0x22: error plus drive 0 flag
        check("R9 error end code", {23'h0, end_fail, end_code}, {23'h0, 1'b1, 8'h32});
        check("R10 error fails", {30'h0, tmo_class}, 32'd1);

        // R10: busy pattern overrides error
        eng_busy = 2'b11; #1;
        check("R10 busy waits", {30'h0, tmo_class}, 32'd0);
        eng_busy = 2'b00; #1;

        // clear error and drive bits: status 0
        step(1'b1, 2'd0, 4'b0100, 32'h0002_0000, 3'b000, 2'b00, 2'd0);
        check("R5 error cleared", reg_rdata, 32'h0000_0008);
        check("R9 empty status code", {23'h0, end_fail, end_code}, {23'h0, 1'b1, 8'h10});
        check("R10 reset bus", {30'h0, tmo_class}, 32'd2);

        // interrupt only: clean end
        step(1'b0, 2'd0, 4'b0000, 32'h0, 3'b001, 2'b00, 2'd0);
        check("R11 irq_out", {31'h0, irq_out}, 32'd1);
        check("R9 clean end", {23'h0, end_fail, end_code}, 32'h0);
        check("R10 irq waits", {30'h0, tmo_class}, 32'd0);
        step(1'b1, 2'd0, 4'b0100, 32'h0004_0000, 3'b000, 2'b00, 2'd0);
        check("R11 irq_out cleared", {31'h0, irq_out}, 32'd0);

        // R2: start with direction toward disk
        step(1'b1, 2'd0, 4'b0001, 32'h0000_0001, 3'b000, 2'b00, 2'd0);
        check("R2 go and dir", {30'h0, dma_go, dma_to_mem}, 32'b10);
        check("R7 active set", reg_rdata, 32'h0001_0001);
        check("R10 active waits", {30'h0, tmo_class}, 32'd0);
        step(1'b0, 2'd0, 4'b0000, 32'h0, 3'b100, 2'b00, 2'd0);
        check("R7 active cleared by done", reg_rdata, 32'h0000_0001);
        // R7: rewriting start while set does not re-arm
        step(1'b1, 2'd0, 4'b0001, 32'h0000_0001, 3'b000, 2'b00, 2'd0);
        check("R7 no re-arm", reg_rdata, 32'h0000_0001);
        // R7: software cannot set active
        step(1'b1, 2'd0, 4'b0100, 32'h0001_0000, 3'b000, 2'b00, 2'd0);
        check("R7 active read-only", reg_rdata, 32'h0000_0001);
        // R2: unused command bits read zero
        step(1'b1, 2'd0, 4'b0001, 32'h0000_00F6, 3'b000, 2'b00, 2'd0);
        check("R2 unused cmd bits", reg_rdata, 32'h0000_0000);

        finish_run();
    end
endmodule